// File: doc/BRIEF.md
# Memory-Mapped 16-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins, controlled through a bank of 32-bit registers on a plain synchronous bus. The bus has a word index, a write strobe, write data and read data. Software picks a two-bit mode for each pin: input, general output, alternate function or analog. It also picks push-pull or open-drain drive and a pull-up or pull-down for each pin. It writes output bits as whole words, or changes single bits with set/clear and clear-only words. From these settings the block works out, for each pin, the value to drive, whether the driver is enabled and which pull resistor to switch on. The pad inputs pass through a two-flop synchronizer into the input data register, and pins in analog mode read as zero there.

A port clock-enable input stands for the gated peripheral clock. While it is low, no register, synchronizer flop or input sample changes, and reads return zero. The bus has no handshake. It accepts one access per cycle and never stalls, so there is no back-pressure. The pad signals are plain per-pin levels. In alternate-function mode the pin drives the value on the `alt_drive` input.

Register word indices (byte offset / 4): 0 mode, 1 output type, 2 speed, 3 pull, 4 input data, 5 output data, 6 set/clear, 7 lock, 8 and 9 alternate-function select, 10 clear, 11 analog switch. Indices 7, 11 and 12–15 are not implemented.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the mode word reads 0xFFFF_FFFF (every pin analog, code 11). The output type, speed, pull, output data and alternate-function words read 0. Every `pad_oe`, `pull_up` and `pull_dn` bit is 0.
- R2: Writing the mode (index 0), speed (2), pull (3) and alternate-function (8, 9) words stores all 32 bits, and they read back unchanged. The output type (1) and output data (5) words keep bits 15:0 and read bits 31:16 as zero. Reads are combinational on the current index.
- R3: While `port_clk_en` is 0, writes have no effect, the input synchronizer and input data register hold their values, and `bus_rdata` is 0.
- R4: A write to the set/clear word (index 6) sets output bit n where data bit n is 1 and clears it where data bit n+16 is 1. Set wins when both bits are 1 for the same pin. The word reads as zero.
- R5: A write to the clear word (index 10) clears output bit n where data bit n is 1 and leaves the others. The word reads as zero.
- R6: Writes to indices 4, 7, 11 and 12–15 change no register. Indices 7 and 11–15 read zero.
- R7: With mode 01 (general output) and push-pull (output type bit 0), `pad_oe[n]`=1 and `pad_out[n]` equals output data bit n, from the cycle after the write.
- R8: With output type bit n = 1 (open-drain) in modes 01 or 10, `pad_oe[n]` is 1 only while the pin's value is 0. `pad_out[n]` still shows the value.
- R9: With mode 10 (alternate function) the pin's value is `alt_drive[n]`, under the same drive rules as R7 and R8. In modes 00 and 11, `pad_oe[n]`=0 and `pad_out[n]`=0.
- R10: Pull code 01 asserts `pull_up[n]` and code 10 asserts `pull_dn[n]`. Codes 00 and 11 assert neither.
- R11: A change on `pad_in` set up before enabled edge k reads in the input data word (index 4, bits 15:0) after enabled edge k+2, not earlier. Pins whose mode is 11 at the capturing edge read 0. Bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_clk_en | input | 1 | Port clock enable; 0 freezes the block and zeroes reads |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Pad input levels |
| alt_drive | input | 16 | Per-pin value from an alternate function |
| pad_out | output | 16 | Per-pin output value |
| pad_oe | output | 16 | Per-pin output-driver enable |
| pull_up | output | 16 | Per-pin pull-up enable |
| pull_dn | output | 16 | Per-pin pull-down enable |

## Verification
Register writes land on the edge that takes them, so read-back and pad resolution are checked at the falling edge one half-cycle later. Reads are combinational and are sampled 1 ns after the index is set. Input data is due two enabled edges after the synchronizer captures `pad_in`: the bench checks that it is unchanged after two edges and present after three. A mode change reaches the analog mask of the input word one enabled edge later, so the random phase inserts an enabled idle cycle before each check.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALTFN  = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'b00,
    PL_UP   = 2'b01,
    PL_DOWN = 2'b10,
    PL_RSVD = 2'b11
  } pin_pull_e;

  localparam logic [3:0] IX_MODE  = 4'd0;
  localparam logic [3:0] IX_OTYPE = 4'd1;
  localparam logic [3:0] IX_SPEED = 4'd2;
  localparam logic [3:0] IX_PULL  = 4'd3;
  localparam logic [3:0] IX_IDATA = 4'd4;
  localparam logic [3:0] IX_ODATA = 4'd5;
  localparam logic [3:0] IX_SETCLR = 4'd6;
  localparam logic [3:0] IX_AFLO  = 4'd8;
  localparam logic [3:0] IX_AFHI  = 4'd9;
  localparam logic [3:0] IX_CLR   = 4'd10;
endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 4,
  localparam int DW  = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] idata,
  output logic [DW-1:0]   mode_q,
  output logic [NPIN-1:0] otype_q,
  output logic [DW-1:0]   pull_q,
  output logic [NPIN-1:0] odata_q
);
  logic [DW-1:0]   speed_q, aflo_q, afhi_q;
  logic [NPIN-1:0] odata_d, set_bits, clr_bits;
  logic            wr;
  logic [DW-1:0]   rd_mux;

  assign wr       = clk_en && bus_we;
  assign set_bits = bus_wdata[NPIN-1:0];
  assign clr_bits = bus_wdata[DW-1:NPIN];

  always_comb begin
    odata_d = odata_q;
    if (wr) begin
      case (bus_addr)
        IX_ODATA:  odata_d = bus_wdata[NPIN-1:0];
        IX_SETCLR: odata_d = (odata_q & ~clr_bits) | set_bits;
        IX_CLR:    odata_d = odata_q & ~set_bits;
        default:   odata_d = odata_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '1;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
      odata_q <= '0;
    end else begin
      odata_q <= odata_d;
      if (wr) begin
        case (bus_addr)
          IX_MODE:  mode_q  <= bus_wdata;
          IX_OTYPE: otype_q <= bus_wdata[NPIN-1:0];
          IX_SPEED: speed_q <= bus_wdata;
          IX_PULL:  pull_q  <= bus_wdata;
          IX_AFLO:  aflo_q  <= bus_wdata;
          IX_AFHI:  afhi_q  <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      IX_MODE:  rd_mux = mode_q;
      IX_OTYPE: rd_mux = {{NPIN{1'b0}}, otype_q};
      IX_SPEED: rd_mux = speed_q;
      IX_PULL:  rd_mux = pull_q;
      IX_IDATA: rd_mux = {{NPIN{1'b0}}, idata};
      IX_ODATA: rd_mux = {{NPIN{1'b0}}, odata_q};
      IX_AFLO:  rd_mux = aflo_q;
      IX_AFHI:  rd_mux = afhi_q;
      default:  rd_mux = '0;
    endcase
    bus_rdata = clk_en ? rd_mux : '0;
  end

  // R3: a disabled cycle leaves every configuration word alone
  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(mode_q) && $stable(odata_q) && $stable(otype_q)
                 && $stable(pull_q) && $stable(speed_q)));

  // R4: set bits land high; clear-only bits land low
  assert_setclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == IX_SETCLR) |=>
      (((odata_q & $past(set_bits)) == $past(set_bits)) &&
       ((odata_q & $past(clr_bits) & ~$past(set_bits)) == '0)));

  // R5: clear word clears addressed bits and keeps the rest
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == IX_CLR) |=>
      (((odata_q & $past(set_bits)) == '0) &&
       ((odata_q & ~$past(set_bits)) == ($past(odata_q) & ~$past(set_bits)))));
endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  localparam int DW  = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   mode_q,
  input  logic [NPIN-1:0] otype_q,
  input  logic [DW-1:0]   pull_q,
  input  logic [NPIN-1:0] odata_q,
  input  logic [NPIN-1:0] alt_drive,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pull_up,
  output logic [NPIN-1:0] pull_dn
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_mode_e m;
    pin_pull_e p;
    logic      val, drives;

    assign m = pin_mode_e'(mode_q[2*i +: 2]);
    assign p = pin_pull_e'(pull_q[2*i +: 2]);

    always_comb begin
      case (m)
        PM_OUTPUT: begin val = odata_q[i];   drives = 1'b1; end
        PM_ALTFN:  begin val = alt_drive[i]; drives = 1'b1; end
        default:   begin val = 1'b0;         drives = 1'b0; end
      endcase
      pad_out[i] = val;
      pad_oe[i]  = drives && (!otype_q[i] || !val);
      pull_up[i] = (p == PL_UP);
      pull_dn[i] = (p == PL_DOWN);
    end

    // R8: an open-drain pin only ever drives low
    assert_opendrain_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (otype_q[i] && pad_oe[i]) |-> !pad_out[i]);
    // R9: input and analog pins never drive
    assert_idle_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b00 || mode_q[2*i +: 2] == 2'b11) |-> (!pad_oe[i] && !pad_out[i]));
    // R10: pull-up and pull-down are never both on
    assert_pull_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_up[i] && pull_dn[i]));
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  localparam int DW  = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic [NPIN-1:0] pad_in,
  input  logic [DW-1:0]   mode_q,
  output logic [NPIN-1:0] idata_q
);
  logic [NPIN-1:0] meta_q, stab_q, analog_mask;

  for (genvar i = 0; i < NPIN; i++) begin : g_mask
    assign analog_mask[i] = (pin_mode_e'(mode_q[2*i +: 2]) == PM_ANALOG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      stab_q  <= '0;
      idata_q <= '0;
    end else if (clk_en) begin
      meta_q  <= pad_in;
      stab_q  <= meta_q;
      idata_q <= stab_q & ~analog_mask;
    end
  end

  // R11: analog pins capture as zero
  assert_analog_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> ((idata_q & $past(analog_mask)) == '0));
  // R3: capture path frozen while disabled
  assert_sync_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(idata_q) && $stable(stab_q)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 4,
  localparam int DW  = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_clk_en,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] alt_drive,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pull_up,
  output logic [NPIN-1:0] pull_dn
);
  logic [DW-1:0]   mode_q, pull_q;
  logic [NPIN-1:0] otype_q, odata_q, idata_q;

  gpio_regbank #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clk_en(port_clk_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .idata(idata_q),
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odata_q(odata_q)
  );

  gpio_pad_resolve #(.NPIN(NPIN)) u_pads (
    .clk(clk), .rst_n(rst_n),
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odata_q(odata_q),
    .alt_drive(alt_drive),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_en(port_clk_en),
    .pad_in(pad_in), .mode_q(mode_q), .idata_q(idata_q)
  );

  // R7: a general-output push-pull pin is always driven
  assert_pushpull_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b01 && !otype_q[0]) |-> (pad_oe[0] && pad_out[0] == odata_q[0]));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_clk_en = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0, alt_drive = '0;
  logic [15:0] pad_out, pad_oe, pull_up, pull_dn;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_mode, m_spd, m_pull, m_af0, m_af1;
  logic [15:0] m_ot, m_odr;

  always #10 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .port_clk_en(port_clk_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .alt_drive(alt_drive),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] analog_mask(input logic [31:0] md);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (md[2*i +: 2] == 2'b11);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return {16'h0, m_ot};
      4'd2: return m_spd;
      4'd3: return m_pull;
      4'd4: return {16'h0, pad_in & ~analog_mask(m_mode)};
      4'd5: return {16'h0, m_odr};
      4'd8: return m_af0;
      4'd9: return m_af1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: m_mode = d;
      4'd1: m_ot = d[15:0];
      4'd2: m_spd = d;
      4'd3: m_pull = d;
      4'd5: m_odr = d[15:0];
      4'd6: m_odr = (m_odr & ~d[31:16]) | d[15:0];
      4'd8: m_af0 = d;
      4'd9: m_af1 = d;
      4'd10: m_odr = m_odr & ~d[15:0];
      default: ;
    endcase
  endtask

  // one write; returns at the falling edge after the capturing rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (port_clk_en) model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, port_clk_en ? exp_read(a) : 32'h0);
  endtask

  task automatic pins_chk(input string req);
    logic [15:0] e_out, e_oe, e_up, e_dn;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] m;
      logic v;
      m = m_mode[2*i +: 2];
      v = (m == 2'b01) ? m_odr[i] : (m == 2'b10) ? alt_drive[i] : 1'b0;
      e_out[i] = v;
      e_oe[i]  = (m == 2'b01 || m == 2'b10) && (!m_ot[i] || !v);
      e_up[i]  = (m_pull[2*i +: 2] == 2'b01);
      e_dn[i]  = (m_pull[2*i +: 2] == 2'b10);
    end
    #1;
    chk({req, " pad_out"}, {16'h0, pad_out}, {16'h0, e_out});
    chk({req, " pad_oe"},  {16'h0, pad_oe},  {16'h0, e_oe});
    chk({req, " pull_up"}, {16'h0, pull_up}, {16'h0, e_up});
    chk({req, " pull_dn"}, {16'h0, pull_dn}, {16'h0, e_dn});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_mode = '1; m_ot = '0; m_spd = '0; m_pull = '0; m_af0 = '0; m_af1 = '0; m_odr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 mode reset", 4'd0);
    rd_chk("R1 odata reset", 4'd5);
    rd_chk("R1 otype reset", 4'd1);
    pins_chk("R1");

    // R2 readback and reserved upper halves
    wr(4'd2, 32'hDEAD_BEEF); rd_chk("R2 speed", 4'd2);
    wr(4'd1, 32'hFFFF_00F0); rd_chk("R2 otype upper zero", 4'd1);
    wr(4'd5, 32'h1234_5678); rd_chk("R2 odata upper zero", 4'd5);
    wr(4'd8, 32'h8765_4321); rd_chk("R2 af low", 4'd8);
    wr(4'd9, 32'h0F1E_2D3C); rd_chk("R2 af high", 4'd9);

    // R7 push-pull output
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h5555_5555);
    wr(4'd5, 32'h0000_C3A5);
    pins_chk("R7 push-pull");

    // R8 open-drain
    wr(4'd1, 32'h0000_FFFF);
    pins_chk("R8 open-drain");
    wr(4'd1, 32'h0000_00FF);
    pins_chk("R8 mixed drive");

    // R9 alternate function and idle modes
    alt_drive = 16'h3C69;
    wr(4'd0, 32'hAAAA_AAAA);
    pins_chk("R9 altfn");
    wr(4'd0, 32'hF0F0_A50F);
    pins_chk("R9 mixed modes");

    // R10 pulls, all four codes
    wr(4'd3, 32'hE4E4_1B1B);
    pins_chk("R10 pulls");

    // R4 set/clear
    wr(4'd5, 32'h0000_00FF);
    wr(4'd6, 32'h0F0F_F0F0);
    rd_chk("R4 set/clear", 4'd5);
    chk("R4 set/clear value", {16'h0, m_odr}, 32'h0000_F0F0);
    wr(4'd6, 32'h0001_0001);
    rd_chk("R4 set wins", 4'd5);
    chk("R4 set wins bit0", {31'h0, m_odr[0]}, 32'h1);
    rd_chk("R4 reads zero", 4'd6);

    // R5 clear
    wr(4'd10, 32'hFFFF_00F1);
    rd_chk("R5 clear", 4'd5);
    chk("R5 value", {16'h0, m_odr}, 32'h0000_F000);
    rd_chk("R5 reads zero", 4'd10);

    // R6 unmapped / read-only indices
    foreach (m_af0[k]) if (k < 1) ; // no-op placeholder-free loop guard
    for (int a = 11; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd_chk("R6 unmapped reads zero", a[3:0]);
    end
    wr(4'd7, 32'hFFFF_FFFF); rd_chk("R6 lock reads zero", 4'd7);
    wr(4'd4, 32'hFFFF_FFFF);
    rd_chk("R6 mode kept", 4'd0);
    rd_chk("R6 odata kept", 4'd5);
    pins_chk("R6");

    // R11 synchronizer latency and analog masking
    wr(4'd0, 32'h0000_0000);
    pad_in = 16'h0000;
    repeat (4) @(negedge clk);
    pad_in = 16'hBEEF;
    repeat (2) @(negedge clk);
    bus_addr = 4'd4; #1;
    chk("R11 not yet after two edges", bus_rdata, 32'h0);
    @(negedge clk);
    rd_chk("R11 present after three edges", 4'd4);
    wr(4'd0, 32'hFF00_00FF);
    @(negedge clk);
    rd_chk("R11 analog pins read zero", 4'd4);

    // R3 gating
    port_clk_en = 1'b0;
    wr(4'd5, 32'h0000_FFFF);
    wr(4'd0, 32'h5555_5555);
    pad_in = 16'h1111;
    repeat (4) @(negedge clk);
    bus_addr = 4'd0; #1;
    chk("R3 read zero when disabled", bus_rdata, 32'h0);
    port_clk_en = 1'b1;
    bus_addr = 4'd4; #1;
    chk("R3 input data frozen", bus_rdata, {16'h0, 16'hBEEF & ~analog_mask(m_mode)});
    rd_chk("R3 mode unchanged", 4'd0);
    rd_chk("R3 odata unchanged", 4'd5);
    pins_chk("R3");

    // random phase (R2, R4, R5, R7..R10 mixed)
    pad_in = 16'h5AC3;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 400; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      port_clk_en = ($urandom_range(0, 9) != 0);
      alt_drive = 16'($urandom);
      wr(a, $urandom);
      port_clk_en = 1'b1;
      @(negedge clk);
      rd_chk("R2 random readback", 4'($urandom_range(0, 15)));
      pins_chk("R9 random pins");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule